// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Stop-Mode Kill

This block is a down-counting watchdog. When enabled, it counts slow ticks from a free-running source that keeps running while the processor core is halted. If software does not service it before the count runs out, the block issues a one-cycle reset request. Three configuration bits are loaded through a write strobe: the enable, a kill-on-stop option and a wake re-arm option.

The kill option decides what happens when the core enters stop. With the option off, the watchdog keeps timing through stop. A stop that lasts too long then ends in a watchdog reset. With the option on, entering stop disables the watchdog and returns its counter to the initial value. On an interrupt wake from stop, the re-arm option restarts the watchdog from its initial value. If re-arm is off, a killed watchdog stays off.

Any reset puts the configuration bits back to their defaults. This includes the watchdog's own reset request. The initial count value is a parameter, and its default is small so that simulation stays short.

Top module: `cop_watchdog`

## Requirements
- R1: After reset, whether at power-up or asserted in the middle of a count, `wdog_reset` is low and the watchdog is disabled. Any number of ticks then produces no reset request.
- R2: A configuration write that sets the enable while the watchdog is off loads the counter with `INIT_VAL`. Each following `tick` decrements it. The reset request appears on the cycle after the `INIT_VAL`-th tick.
- R3: A `service` pulse while enabled reloads the counter with `INIT_VAL`, so a full window of `INIT_VAL` ticks is needed again. If `service` and `tick` fall in the same cycle, the service wins and no decrement happens.
- R4: `wdog_reset` is high for exactly one clock cycle per time-out.
- R5: The cycle after a reset request, enable, kill-on-stop and wake re-arm all return to their default of 0. No further reset request follows, whatever ticks arrive.
- R6: With kill-on-stop at 0, a `stop_req` does not affect counting. A time-out during stop still raises the reset request.
- R7: With kill-on-stop at 1, a `stop_req` disables the watchdog and reloads the counter. No reset request follows, however many ticks arrive during stop.
- R8: On a `wake_irq` while stopped with wake re-arm at 1, the watchdog is enabled and its counter loaded with `INIT_VAL`. This holds whether the watchdog had been killed or was still running. The reset request then follows `INIT_VAL` ticks later.
- R9: On a `wake_irq` with wake re-arm at 0 after a kill, the watchdog stays disabled.
- R10: While disabled, ticks leave the counter unchanged. A `wake_irq` outside stop is ignored, even with wake re-arm set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Loads the three configuration bits below |
| cfg_enable | input | 1 | Watchdog enable value |
| cfg_kill_on_stop | input | 1 | 1: stop entry disables the watchdog |
| cfg_wake_rearm | input | 1 | 1: interrupt wake restarts the watchdog |
| service | input | 1 | Service strobe, reloads the counter when enabled |
| stop_req | input | 1 | Stop-entry strobe |
| wake_irq | input | 1 | Interrupt wake strobe |
| tick | input | 1 | Free-running count tick, active through stop |
| wdog_reset | output | 1 | One-cycle watchdog reset request |

## Verification
The bench aims at the last cycle of the count window. It checks that a service landing together with the final tick suppresses the time-out. A design that lets the tick win there would reset a healthy system. It runs stop entry with each kill setting. A design that ignores the option either lets a killed watchdog fire during stop or silently stops timing a hung stop. It also checks wake with and without re-arm, a wake strobe outside stop, and the behaviour after a time-out. A design that keeps its configuration after barking, or that reloads on every wake, shows up as an extra or a missing reset request at a predictable cycle.

// File: rtl/cop_wdg_pkg.sv
package cop_wdg_pkg;

  typedef struct packed {
    logic enable;
    logic kill_on_stop;
    logic wake_rearm;
  } wdg_cfg_t;

  localparam wdg_cfg_t CFG_DEFAULT = '{enable: 1'b0, kill_on_stop: 1'b0, wake_rearm: 1'b0};

endpackage

// File: rtl/cop_wdg_rst_sync.sv
module cop_wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cop_wdg_sleep.sv
module cop_wdg_sleep (
  input  logic clk,
  input  logic rst_n,
  input  logic bark,
  input  logic stop_req,
  input  logic wake_irq,
  output logic stop_evt,
  output logic wake_evt
);
  logic asleep_q, asleep_d;

  assign stop_evt = stop_req & ~asleep_q;
  assign wake_evt = wake_irq & asleep_q;

  always_comb begin
    asleep_d = asleep_q;
    if (bark)          asleep_d = 1'b0;
    else if (stop_evt) asleep_d = 1'b1;
    else if (wake_evt) asleep_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) asleep_q <= 1'b0;
    else        asleep_q <= asleep_d;
  end

  // A wake strobe never finds the core asleep on the following cycle
  assert_wake_leaves_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !stop_req) |=> !asleep_q);
endmodule

// File: rtl/cop_wdg_cfg.sv
module cop_wdg_cfg
  import cop_wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bark,
  input  logic     cfg_wr,
  input  wdg_cfg_t cfg_in,
  input  logic     stop_evt,
  input  logic     wake_evt,
  output wdg_cfg_t cfg,
  output logic     load_req
);
  wdg_cfg_t cfg_q, cfg_d;
  logic     kill_hit, rearm_hit, enable_rise;

  assign kill_hit    = stop_evt & cfg_q.kill_on_stop;
  assign rearm_hit   = wake_evt & cfg_q.wake_rearm;
  assign enable_rise = cfg_wr & cfg_in.enable & ~cfg_q.enable;

  always_comb begin
    cfg_d = cfg_q;
    if (bark)           cfg_d = CFG_DEFAULT;
    else if (cfg_wr)    cfg_d = cfg_in;
    else if (kill_hit)  cfg_d.enable = 1'b0;
    else if (rearm_hit) cfg_d.enable = 1'b1;
  end

  assign load_req = ~bark & (enable_rise | (~cfg_wr & (kill_hit | rearm_hit)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_DEFAULT;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  assert_bark_clears_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bark |=> (cfg_q == CFG_DEFAULT));

  assert_kill_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && cfg_q.kill_on_stop && !cfg_wr && !bark) |=> !cfg_q.enable);

  assert_no_kill_keeps_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !cfg_q.kill_on_stop && !cfg_wr && !bark && !wake_evt)
      |=> (cfg_q.enable == $past(cfg_q.enable)));

  assert_wake_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && cfg_q.wake_rearm && !cfg_wr && !bark) |=> cfg_q.enable);

  assert_wake_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !cfg_q.wake_rearm && !cfg_q.enable && !cfg_wr) |=> !cfg_q.enable);
endmodule

// File: rtl/cop_wdg_count.sv
module cop_wdg_count #(
  parameter int CNT_W    = 8,
  parameter int INIT_VAL = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic load_req,
  input  logic service,
  input  logic tick,
  output logic bark
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INIT_VAL);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bark_q, bark_d;
  logic             cnt_en;

  assign cnt_en = enable & tick & (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    bark_d = 1'b0;
    if (bark_q || load_req) begin
      cnt_d = RELOAD;
    end else if (enable && service) begin
      cnt_d = RELOAD;
    end else if (cnt_en) begin
      cnt_d  = cnt_q - LAST;
      bark_d = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      bark_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bark_q <= bark_d;
    end
  end

  assign bark = bark_q;

  assert_bark_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bark_q |=> !bark_q);

  assert_bark_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bark_q) |-> ($past(tick) && $past(enable) && !$past(service)));

  assert_service_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && service && !bark_q) |=> (cnt_q == RELOAD && !bark_q));

  assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load_req && !bark_q) |=> $stable(cnt_q));
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_wdg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int INIT_VAL = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_enable,
  input  logic cfg_kill_on_stop,
  input  logic cfg_wake_rearm,
  input  logic service,
  input  logic stop_req,
  input  logic wake_irq,
  input  logic tick,
  output logic wdog_reset
);
  logic     rst_n_s;
  logic     bark, stop_evt, wake_evt, load_req;
  wdg_cfg_t cfg_in, cfg;

  assign cfg_in = '{enable: cfg_enable, kill_on_stop: cfg_kill_on_stop, wake_rearm: cfg_wake_rearm};

  cop_wdg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  cop_wdg_sleep u_sleep (
    .clk(clk), .rst_n(rst_n_s), .bark(bark), .stop_req(stop_req),
    .wake_irq(wake_irq), .stop_evt(stop_evt), .wake_evt(wake_evt)
  );

  cop_wdg_cfg u_cfg (
    .clk(clk), .rst_n(rst_n_s), .bark(bark), .cfg_wr(cfg_wr), .cfg_in(cfg_in),
    .stop_evt(stop_evt), .wake_evt(wake_evt), .cfg(cfg), .load_req(load_req)
  );

  cop_wdg_count #(.CNT_W(CNT_W), .INIT_VAL(INIT_VAL)) u_count (
    .clk(clk), .rst_n(rst_n_s), .enable(cfg.enable), .load_req(load_req),
    .service(service), .tick(tick), .bark(bark)
  );

  assign wdog_reset = bark;

  // A disabled watchdog cannot raise a request on the next cycle
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cfg.enable && !load_req) |=> !wdog_reset);
endmodule

// File: tb/cop_watchdog_tb_top.sv
`timescale 1ns/100ps
module cop_watchdog_tb_top;
  localparam int INIT = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_enable, cfg_kill_on_stop, cfg_wake_rearm;
  logic service, stop_req, wake_irq, tick;
  logic wdog_reset;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  string cur_req = "R1";

  int    exp_q[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cop_watchdog #(.CNT_W(8), .INIT_VAL(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_kill_on_stop(cfg_kill_on_stop), .cfg_wake_rearm(cfg_wake_rearm),
    .service(service), .stop_req(stop_req), .wake_irq(wake_irq), .tick(tick),
    .wdog_reset(wdog_reset)
  );

  // Monitor: every reset request must match the oldest expectation
  always @(negedge clk) begin
    if (rst_n && wdog_reset) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL %s: unexpected wdog_reset at cycle %0d, expected none", cur_req, cyc);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        if (e != cyc) begin
          failures++;
          $display("FAIL %s: wdog_reset at cycle %0d, expected cycle %0d", t, cyc, e);
        end
      end
    end
  end

  task automatic expect_bark(input string r);
    exp_q.push_back(cyc + 1);
    exp_tag.push_back(r);
  endtask

  task automatic write_cfg(input logic en, input logic kill, input logic rearm);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_enable = en; cfg_kill_on_stop = kill; cfg_wake_rearm = rearm;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_service(input logic with_tick);
    @(negedge clk);
    service = 1'b1; tick = with_tick;
    @(negedge clk);
    service = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
  endtask

  task automatic tick_n(input int n, input bit bark_last, input string r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      if (bark_last && i == n - 1) expect_bark(r);
      @(negedge clk);
      tick = 1'b0;
    end
    if (bark_last) begin
      @(negedge clk);
      checks++;
      if (wdog_reset !== 1'b0) begin
        failures++;
        $display("FAIL R4: wdog_reset=%b one cycle after pulse, expected 0", wdog_reset);
      end
    end
  endtask

  task automatic drained(input string r);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s: %0d expected reset request(s) missing, expected 0", r, exp_q.size());
      exp_q.delete();
      exp_tag.delete();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr = 0; cfg_enable = 0; cfg_kill_on_stop = 0; cfg_wake_rearm = 0;
    service = 0; stop_req = 0; wake_irq = 0; tick = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, then ticks with no enable
    cur_req = "R1";
    checks++;
    if (wdog_reset !== 1'b0) begin
      failures++;
      $display("FAIL R1: wdog_reset=%b after reset, expected 0", wdog_reset);
    end
    tick_n(10, 0, "R1");
    drained("R1");

    // R2: full window, then R5: defaults restored after the request
    cur_req = "R2";
    write_cfg(1, 0, 0);
    tick_n(INIT, 1, "R2");
    drained("R2");
    cur_req = "R5";
    tick_n(20, 0, "R5");
    drained("R5");

    // R3: service mid-window restarts it
    cur_req = "R3";
    write_cfg(1, 0, 0);
    tick_n(4, 0, "R3");
    pulse_service(0);
    tick_n(INIT, 1, "R3");
    drained("R3");

    // R3: service on the same cycle as the final tick wins
    write_cfg(1, 0, 0);
    tick_n(INIT - 1, 0, "R3");
    pulse_service(1);
    tick_n(INIT, 1, "R3");
    drained("R3");

    // R6: stop without kill keeps counting to a time-out
    cur_req = "R6";
    write_cfg(1, 0, 0);
    tick_n(3, 0, "R6");
    pulse_stop();
    tick_n(INIT - 3, 1, "R6");
    drained("R6");
    // R10: wake outside stop after the bark changes nothing
    cur_req = "R10";
    pulse_wake();
    tick_n(15, 0, "R10");
    drained("R10");

    // R7: stop with kill disables; R9: wake without re-arm stays off
    cur_req = "R7";
    write_cfg(1, 1, 0);
    tick_n(3, 0, "R7");
    pulse_stop();
    tick_n(20, 0, "R7");
    drained("R7");
    cur_req = "R9";
    pulse_wake();
    tick_n(20, 0, "R9");
    drained("R9");

    // R8: kill then wake with re-arm restarts from the initial value
    cur_req = "R8";
    write_cfg(1, 1, 1);
    tick_n(2, 0, "R8");
    pulse_stop();
    tick_n(10, 0, "R8");
    pulse_wake();
    tick_n(INIT, 1, "R8");
    drained("R8");

    // R8: running through stop, wake with re-arm reloads the count
    write_cfg(1, 0, 1);
    tick_n(4, 0, "R8");
    pulse_stop();
    tick_n(1, 0, "R8");
    pulse_wake();
    tick_n(INIT, 1, "R8");
    drained("R8");

    // R10: disabled with re-arm set, wake outside stop ignored
    cur_req = "R10";
    write_cfg(0, 0, 1);
    pulse_wake();
    tick_n(20, 0, "R10");
    drained("R10");

    // R1: reset in the middle of a count
    cur_req = "R1";
    write_cfg(1, 0, 0);
    tick_n(3, 0, "R1");
    do_reset();
    checks++;
    if (wdog_reset !== 1'b0) begin
      failures++;
      $display("FAIL R1: wdog_reset=%b after mid-run reset, expected 0", wdog_reset);
    end
    tick_n(20, 0, "R1");
    drained("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule